// File: doc/BRIEF.md
# Programmable Bus Latency Injector

This block adds a software-chosen number of wait cycles to the responses on a set of request/response channels. It makes a fast prototype memory system look as slow as real silicon. Channel 0 sits on the path from the system arbiter to the memory controller, so its delay reaches every memory access. Channels 1 to 12 each sit on one arbiter port and hold their own delay.

Configuration is indirect and uses a word-addressed write port. Software first names a channel in a select register. It then writes a cycle count to a value register, and that count lands only in the named channel. On each channel the request handshake passes straight through while the channel is idle. A response travels with no added cycles while the channel's delay is zero. With a nonzero delay the response is captured, held for that many cycles, and then offered downstream. The channel accepts no new request until the held response has been taken.

Top module: `lat_injector`

## Requirements
- R1: After reset the select and value registers both read 0, and every channel has a delay of 0.
- R2: A write to word address 21 stores the low 8 bits of the write data as the selected unit. A read of address 21 returns that value zero-extended. Any address other than 21 or 22 reads 0.
- R3: A write to word address 22 stores the low 6 bits of the write data, and a read of address 22 returns them zero-extended. The same write sets the delay of the channel whose number is held in the select register.
- R4: While the select register holds a number above 12, writes to address 22 leave the delay of every channel unchanged.
- R5: A channel with a delay of 0 and no held response connects combinationally: response valid and data go from the slave side to the master side, and ready goes from the master side to the slave side.
- R6: A channel with delay N>0 and no held response accepts a slave response at once (slave-side ready high). It raises master-side response valid exactly N clock edges after the accepting edge, carrying the captured data, and keeps it raised until it is accepted.
- R7: While a response is held, slave-side response ready is low.
- R8: While a response is held, the request path of that channel is stalled: master-side request ready and slave-side request valid are both low.
- R9: The hold ends on the edge where master-side response valid and ready are both high. From the next cycle the request path passes through again.
- R10: Each channel keeps its own delay and its own hold state, and programming or loading one channel does not affect another. Channel 0 behaves exactly like the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Word address for write and read |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Read data for cfg_addr (combinational) |
| m_req_valid | input | NCH | Request valid from requesters |
| m_req_ready | output | NCH | Request ready to requesters |
| s_req_valid | output | NCH | Request valid toward responders |
| s_req_ready | input | NCH | Request ready from responders |
| s_rsp_valid | input | NCH | Response valid from responders |
| s_rsp_ready | output | NCH | Response ready to responders |
| s_rsp_data | input | NCH*RSP_W | Response payload from responders, channel i at bits i*RSP_W |
| m_rsp_valid | output | NCH | Delayed response valid to requesters |
| m_rsp_ready | input | NCH | Response ready from requesters |
| m_rsp_data | output | NCH*RSP_W | Delayed response payload to requesters |

## Verification
The bench builds the block with its default parameters: thirteen channels, 6-bit delays, 8-bit payloads and the select and value registers at words 21 and 22. The full 0 to 63 delay range, the select boundary at 12 and unit numbers 13 to 15 can therefore all be reached. Random program-then-measure rounds check each latency against a bench model of the delay table. They also show that values written after an out-of-range select are dropped, and that a delay of 0 falls back to a direct connection.

// File: rtl/lat_injector.sv
module lat_injector #(
  parameter int NCH      = 13,
  parameter int LAT_W    = 6,
  parameter int RSP_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int CFG_W    = 32,
  parameter int SEL_W    = 8,
  parameter int SEL_ADDR = 21,
  parameter int VAL_ADDR = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic [NCH-1:0]       m_req_valid,
  output logic [NCH-1:0]       m_req_ready,
  output logic [NCH-1:0]       s_req_valid,
  input  logic [NCH-1:0]       s_req_ready,
  input  logic [NCH-1:0]       s_rsp_valid,
  output logic [NCH-1:0]       s_rsp_ready,
  input  logic [NCH*RSP_W-1:0] s_rsp_data,
  output logic [NCH-1:0]       m_rsp_valid,
  input  logic [NCH-1:0]       m_rsp_ready,
  output logic [NCH*RSP_W-1:0] m_rsp_data
);

  logic [SEL_W-1:0] sel_q;
  logic [LAT_W-1:0] val_q;
  logic [NCH-1:0]   busy_vec;

  wire wr_sel = cfg_we && (cfg_addr == ADDR_W'(SEL_ADDR));
  wire wr_val = cfg_we && (cfg_addr == ADDR_W'(VAL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      val_q <= '0;
    end else begin
      if (wr_sel) sel_q <= cfg_wdata[SEL_W-1:0];
      if (wr_val) val_q <= cfg_wdata[LAT_W-1:0];
    end
  end

  assign cfg_rdata = (cfg_addr == ADDR_W'(SEL_ADDR)) ? CFG_W'(sel_q) :
                     (cfg_addr == ADDR_W'(VAL_ADDR)) ? CFG_W'(val_q) : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [LAT_W-1:0] lat;
    logic [LAT_W-1:0] cnt;
    logic [RSP_W-1:0] hold;
    logic             busy;

    wire pass    = (lat == '0);
    wire capture = !busy && !pass && s_rsp_valid[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat <= '0;
      else if (wr_val && sel_q == SEL_W'(i)) lat <= cfg_wdata[LAT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy <= 1'b0;
        cnt  <= '0;
        hold <= '0;
      end else if (capture) begin
        busy <= 1'b1;
        cnt  <= lat;
        hold <= s_rsp_data[i*RSP_W +: RSP_W];
      end else if (busy) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (m_rsp_ready[i]) busy <= 1'b0;
      end
    end

    assign busy_vec[i]    = busy;
    assign m_rsp_valid[i] = busy ? (cnt == '0) : (pass && s_rsp_valid[i]);
    assign s_rsp_ready[i] = busy ? 1'b0 : (pass ? m_rsp_ready[i] : 1'b1);
    assign m_rsp_data[i*RSP_W +: RSP_W] = busy ? hold : s_rsp_data[i*RSP_W +: RSP_W];
    assign s_req_valid[i] = m_req_valid[i] && !busy;
    assign m_req_ready[i] = s_req_ready[i] && !busy;
  end

endmodule

// File: rtl/lat_injector_chk.sv
module lat_injector_chk #(
  parameter int NCH   = 13,
  parameter int RSP_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       busy_vec,
  input logic [NCH-1:0]       m_req_ready,
  input logic [NCH-1:0]       s_req_valid,
  input logic [NCH-1:0]       s_rsp_ready,
  input logic [NCH-1:0]       m_rsp_valid,
  input logic [NCH-1:0]       m_rsp_ready,
  input logic [NCH*RSP_W-1:0] m_rsp_data
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_hold_blocks_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_vec[i] |-> !s_rsp_ready[i]);
    p_hold_stalls_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_vec[i] |-> (!m_req_ready[i] && !s_req_valid[i]));
    p_valid_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_vec[i] && m_rsp_valid[i] && !m_rsp_ready[i]) |=>
        (m_rsp_valid[i] && $stable(m_rsp_data[i*RSP_W +: RSP_W])));
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_vec[i] && m_rsp_valid[i] && m_rsp_ready[i]) |=> !busy_vec[i]);
  end
endmodule

bind lat_injector lat_injector_chk #(.NCH(NCH), .RSP_W(RSP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy_vec(busy_vec),
  .m_req_ready(m_req_ready), .s_req_valid(s_req_valid),
  .s_rsp_ready(s_rsp_ready), .m_rsp_valid(m_rsp_valid),
  .m_rsp_ready(m_rsp_ready), .m_rsp_data(m_rsp_data)
);

// File: tb/test_lat_injector.sv
module test_lat_injector;
  localparam int NCH = 13, RSP_W = 8, ADDR_W = 8, CFG_W = 32;
  localparam int SEL_A = 21, VAL_A = 22;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0, cfg_rdata;
  logic [NCH-1:0] m_req_valid = '0, m_req_ready, s_req_valid, s_req_ready = '1;
  logic [NCH-1:0] s_rsp_valid = '0, s_rsp_ready, m_rsp_valid, m_rsp_ready = '0;
  logic [NCH*RSP_W-1:0] s_rsp_data = '0, m_rsp_data;

  int checks = 0, errors = 0;
  int exp_lat [NCH];
  int exp_sel = 0, exp_val = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lat_injector i_lat_injector (.*);

  function automatic int exp_read(int a);
    if (a == SEL_A) return exp_sel;
    if (a == VAL_A) return exp_val;
    return 0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [CFG_W-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = ADDR_W'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == SEL_A) exp_sel = int'(d[7:0]);
    if (a == VAL_A) begin
      exp_val = int'(d[5:0]);
      if (exp_sel <= 12) exp_lat[exp_sel] = exp_val;
    end
  endtask

  task automatic rd(int a, string req);
    cfg_addr = ADDR_W'(a);
    #1;
    check(cfg_rdata == CFG_W'(exp_read(a)), req, cfg_rdata, exp_read(a));
  endtask

  task automatic measure(int ch, string req);
    int d = exp_lat[ch];
    int waited = 0;
    logic [RSP_W-1:0] dat = RSP_W'($urandom);
    @(negedge clk);
    m_req_valid[ch] = 1;
    s_rsp_valid[ch] = 1;
    s_rsp_data[ch*RSP_W +: RSP_W] = dat;
    #1;
    if (d == 0) begin
      check(m_rsp_valid[ch] == 1, {req, " R5 valid"}, m_rsp_valid[ch], 1);
      check(m_rsp_data[ch*RSP_W +: RSP_W] == dat, {req, " R5 data"}, m_rsp_data[ch*RSP_W +: RSP_W], dat);
      check(s_rsp_ready[ch] == 0, {req, " R5 ready low"}, s_rsp_ready[ch], 0);
      m_rsp_ready[ch] = 1; #1;
      check(s_rsp_ready[ch] == 1, {req, " R5 ready high"}, s_rsp_ready[ch], 1);
      @(negedge clk);
      s_rsp_valid[ch] = 0; m_rsp_ready[ch] = 0; #1;
      check(m_req_ready[ch] && s_req_valid[ch], {req, " R5 req open"}, m_req_ready[ch], 1);
    end else begin
      check(s_rsp_ready[ch] == 1, {req, " R6 accept"}, s_rsp_ready[ch], 1);
      @(negedge clk);
      s_rsp_valid[ch] = 0;
      while (!m_rsp_valid[ch] && waited < 100) begin
        check(s_rsp_ready[ch] == 0, {req, " R7"}, s_rsp_ready[ch], 0);
        check(!m_req_ready[ch] && !s_req_valid[ch], {req, " R8"}, m_req_ready[ch], 0);
        @(negedge clk);
        waited++;
      end
      check(waited == d, {req, " R6 latency"}, waited, d);
      check(m_rsp_data[ch*RSP_W +: RSP_W] == dat, {req, " R6 data"}, m_rsp_data[ch*RSP_W +: RSP_W], dat);
      check(!m_req_ready[ch], {req, " R8 still held"}, m_req_ready[ch], 0);
      m_rsp_ready[ch] = 1;
      @(negedge clk);
      m_rsp_ready[ch] = 0; #1;
      check(m_req_ready[ch] && s_req_valid[ch], {req, " R9 req open"}, m_req_ready[ch], 1);
      check(m_rsp_valid[ch] == 0, {req, " R9 valid drop"}, m_rsp_valid[ch], 0);
    end
    m_req_valid[ch] = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    foreach (exp_lat[i]) exp_lat[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(SEL_A, "R1 sel reset");
    rd(VAL_A, "R1 val reset");
    for (int c = 0; c < NCH; c++) measure(c, "R1 zero delay");

    wr(SEL_A, 32'hFFFF_FF05); rd(SEL_A, "R2 low bits");
    rd(3, "R2 other addr");
    wr(VAL_A, 32'hFFFF_FFC9); rd(VAL_A, "R3 low bits");
    measure(5, "R3 programmed");

    wr(SEL_A, 12); wr(VAL_A, 63); measure(12, "R3 unit 12 max");
    wr(SEL_A, 13); wr(VAL_A, 4);
    rd(VAL_A, "R4 value readback");
    for (int c = 0; c < NCH; c++) measure(c, "R4 ignored");

    wr(SEL_A, 0); wr(VAL_A, 1); measure(0, "R10 unit0 delay1");
    wr(SEL_A, 3); wr(VAL_A, 7); wr(SEL_A, 4); wr(VAL_A, 2);
    measure(3, "R10 ch3"); measure(4, "R10 ch4");
    wr(SEL_A, 4); wr(VAL_A, 0); measure(4, "R5 back to zero");

    repeat (40) begin
      int u = int'($urandom % 16);
      int v = int'($urandom % 64);
      wr(SEL_A, u); wr(VAL_A, v);
      rd(SEL_A, "R2 random");
      measure(int'($urandom % NCH), "R10 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule